// File: doc/BRIEF.md
# Ethernet startup reset sequencer

This block produces the reset pulse for a serial Ethernet PHY and the reset for the MAC clock domain in an FPGA control-bus design. It watches four inputs: a clock-manager lock flag, a reload request, the PHY's reset-done flag and the lock flag of the PHY's own clock manager. All four are brought into the local clock through two-flop synchronizers before any decision uses them.

The PHY is held in reset while a reload is requested or the clock manager is unlocked. Every pulse is stretched to a programmable minimum length. Once the PHY reset is released, the block waits for the PHY to report both reset done and locked. That event sets a sticky "link established" latch, which releases the MAC-domain reset. If the event does not arrive within a watchdog window, the PHY reset is issued again. A saturating retry counter records these attempts, and an error flag rises once the count reaches a limit. Retries continue after the flag rises.

A link-ready output combines the latch with the clock-manager lock, so a status LED blinker can be gated from it directly.

Top module: `eth_rst_seq`

## Requirements
- R1: Each of the four inputs passes through two flip-flops before use. A reload request that is present before clock edge k leaves `phy_rst_o` low after edges k and k+1, and sets it high after edge k+2.
- R2: `phy_rst_o` is high while the synchronized reload is high or the synchronized manager lock is low. After both conditions clear, it stays high for MIN_PULSE further cycles, so it is observed high for MIN_PULSE+1 cycles after the input change.
- R3: The PHY counts as established only when PHY reset-done and PHY lock are both high while `phy_rst_o` is low. Reset-done alone does not release the MAC reset.
- R4: The established latch is sticky. Later loss of PHY reset-done or of the manager lock does not set `mac_rst_o` again. After a lock loss, the PHY reset reruns and the block returns to the up state without waiting for the PHY again.
- R5: `mac_rst_o` is high exactly while the established latch is clear.
- R6: After `phy_rst_o` falls, if the PHY is not established within TIMEOUT cycles, `phy_rst_o` rises again. It is low for exactly TIMEOUT cycles, and `retry_cnt_o` increments on the same edge.
- R7: `retry_cnt_o` saturates at 2^RETRY_W-1. `retry_err_o` is high exactly when the count is at least MAX_RETRY. Retries continue after saturation.
- R8: `link_ready_o` is high exactly when the established latch is set and the synchronized manager lock is high.
- R9: A synchronized reload clears the established latch, the watchdog and the retry counter, so `retry_cnt_o` and `retry_err_o` read 0 and `mac_rst_o` reads 1.
- R10: While `rst` is high, `phy_rst_o`=1, `mac_rst_o`=1, `link_ready_o`=0, `retry_cnt_o`=0 and `retry_err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high full reset |
| mgr_locked_i | input | 1 | Clock-manager lock, asynchronous |
| reload_i | input | 1 | Reload request, asynchronous |
| phy_done_i | input | 1 | PHY reset-done flag, asynchronous |
| phy_lock_i | input | 1 | PHY clock-manager lock, asynchronous |
| phy_rst_o | output | 1 | Reset to the PHY |
| mac_rst_o | output | 1 | Reset for the MAC clock domain |
| link_ready_o | output | 1 | Link established and manager locked |
| retry_cnt_o | output | RETRY_W | Saturating count of watchdog retries |
| retry_err_o | output | 1 | Retry count has reached MAX_RETRY |

## Verification
A stuck sequencer state shows at the ports as `phy_rst_o` held at one level for longer than MIN_PULSE+1 or TIMEOUT cycles. The watchdog retry makes such a fault visible within one window, not only after an indefinite hang. An established latch that loses its value shows in `mac_rst_o` in the next cycle. A wrong pulse or window counter moves the edges of `phy_rst_o` by whole cycles, and the bench measures those edges exactly. A retry counter that wraps or misses an increment differs on `retry_cnt_o` at the edge where `phy_rst_o` rises.

// File: rtl/eth_rst_pkg.sv
package eth_rst_pkg;

    typedef enum logic [1:0] {
        SEQ_HOLD = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_UP   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic reload;
        logic mgr_lock;
        logic phy_done;
        logic phy_lock;
    } seq_in_t;

    localparam int unsigned SEQ_IN_W = $bits(seq_in_t);

    function automatic logic seq_hold(input seq_in_t s);
        return s.reload | ~s.mgr_lock;
    endfunction

    function automatic logic seq_eth_locked(input seq_in_t s);
        return s.phy_done & s.phy_lock;
    endfunction

endpackage

// File: rtl/eth_rst_sync.sv
module eth_rst_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= {chain_q[STAGES-2:0], d_i[g]};
        end
        assign q_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/eth_rst_fsm.sv
module eth_rst_fsm
    import eth_rst_pkg::*;
#(
    parameter int unsigned MIN_PULSE = 16,
    parameter int unsigned TIMEOUT   = 1 << 20
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    input  logic elock_i,
    input  logic done_i,
    output logic phy_rst_o,
    output logic retry_evt_o
);
    localparam int unsigned PC_W = (MIN_PULSE > 1) ? $clog2(MIN_PULSE) : 1;
    localparam int unsigned WD_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(MIN_PULSE - 1);
    localparam logic [WD_W-1:0] WD_LAST = WD_W'(TIMEOUT - 1);

    seq_state_e      state_q;
    logic [PC_W-1:0] pc_q;
    logic [WD_W-1:0] wd_q;

    assign phy_rst_o   = (state_q == SEQ_HOLD);
    assign retry_evt_o = (state_q == SEQ_WAIT) && !hold_i && !elock_i
                         && !done_i && (wd_q == WD_LAST);

    always_ff @(posedge clk) begin
        if (rst || hold_i) begin
            state_q <= SEQ_HOLD;
            pc_q    <= '0;
            wd_q    <= '0;
        end else begin
            unique case (state_q)
                SEQ_HOLD: begin
                    wd_q <= '0;
                    if (pc_q == PC_LAST) begin
                        state_q <= SEQ_WAIT;
                        pc_q    <= '0;
                    end else begin
                        pc_q <= pc_q + 1'b1;
                    end
                end
                SEQ_WAIT: begin
                    if (elock_i || done_i) begin
                        state_q <= SEQ_UP;
                    end else if (wd_q == WD_LAST) begin
                        state_q <= SEQ_HOLD;
                        wd_q    <= '0;
                        pc_q    <= '0;
                    end else begin
                        wd_q <= wd_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_UP;
            endcase
        end
    end

    AST_HOLD_FORCES_RST: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> phy_rst_o);                                   // R2
    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(phy_rst_o) |-> !$past(hold_i));                    // R2
    AST_WDOG_REISSUE: assert property (@(posedge clk) disable iff (rst)
        retry_evt_o |=> phy_rst_o);                              // R6
endmodule

// File: rtl/eth_rst_retry.sv
module eth_rst_retry #(
    parameter int unsigned RETRY_W   = 4,
    parameter int unsigned MAX_RETRY = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_i,
    input  logic               evt_i,
    output logic [RETRY_W-1:0] cnt_o,
    output logic               err_o
);
    localparam logic [RETRY_W-1:0] CNT_MAX = '1;
    localparam logic [RETRY_W:0]   ERR_AT  = (RETRY_W+1)'(MAX_RETRY);

    logic [RETRY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)                   cnt_q <= '0;
        else if (evt_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
    assign err_o = {1'b0, cnt_q} >= ERR_AT;

    AST_RETRY_SAT: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX) && !clr_i |=> cnt_q == CNT_MAX);      // R7
    AST_RETRY_CLR: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> cnt_q == '0);                                  // R9
endmodule

// File: rtl/eth_rst_seq.sv
module eth_rst_seq
    import eth_rst_pkg::*;
#(
    parameter int unsigned MIN_PULSE = 16,
    parameter int unsigned TIMEOUT   = 1 << 20,
    parameter int unsigned RETRY_W   = 4,
    parameter int unsigned MAX_RETRY = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mgr_locked_i,
    input  logic               reload_i,
    input  logic               phy_done_i,
    input  logic               phy_lock_i,
    output logic               phy_rst_o,
    output logic               mac_rst_o,
    output logic               link_ready_o,
    output logic [RETRY_W-1:0] retry_cnt_o,
    output logic               retry_err_o
);
    seq_in_t raw, syn;
    logic    hold, elock, retry_evt, done_q;

    assign raw = '{reload: reload_i, mgr_lock: mgr_locked_i,
                   phy_done: phy_done_i, phy_lock: phy_lock_i};

    eth_rst_sync #(.W(SEQ_IN_W), .STAGES(2)) u_sync (
        .clk (clk), .rst (rst), .d_i (raw), .q_o (syn)
    );

    assign hold  = seq_hold(syn);
    assign elock = seq_eth_locked(syn);

    eth_rst_fsm #(.MIN_PULSE(MIN_PULSE), .TIMEOUT(TIMEOUT)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .hold_i      (hold),
        .elock_i     (elock),
        .done_i      (done_q),
        .phy_rst_o   (phy_rst_o),
        .retry_evt_o (retry_evt)
    );

    eth_rst_retry #(.RETRY_W(RETRY_W), .MAX_RETRY(MAX_RETRY)) u_retry (
        .clk   (clk),
        .rst   (rst),
        .clr_i (syn.reload),
        .evt_i (retry_evt),
        .cnt_o (retry_cnt_o),
        .err_o (retry_err_o)
    );

    // Sticky established latch; only a full reset or a reload clears it.
    always_ff @(posedge clk) begin
        if (rst || syn.reload)        done_q <= 1'b0;
        else if (elock && !phy_rst_o) done_q <= 1'b1;
    end

    assign mac_rst_o    = ~done_q;
    assign link_ready_o = done_q & syn.mgr_lock;

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done_q && !syn.reload |=> done_q);                       // R4
    AST_MAC_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        $fell(mac_rst_o) |-> $past(elock));                      // R3
    AST_LINK_NO_MAC_RST: assert property (@(posedge clk) disable iff (rst)
        link_ready_o |-> !mac_rst_o);                            // R8
    AST_RELOAD_DROPS_MAC: assert property (@(posedge clk) disable iff (rst)
        syn.reload |=> mac_rst_o);                               // R9
endmodule

// File: tb/tb_eth_rst_seq.sv
module tb_eth_rst_seq;
    localparam int MIN_P = 16;
    localparam int TO_P  = 64;
    localparam int MAX_R = 3;
    localparam int RW    = 3;
    localparam int RMAX  = (1 << RW) - 1;

    logic clk = 1'b0, rst = 1'b1;
    logic reload = 1'b0, lock = 1'b1, pdone = 1'b0, plock = 1'b0;
    logic phy_rst, mac_rst, link, err;
    logic [RW-1:0] rcnt;

    always #5 clk = ~clk;

    eth_rst_seq #(.MIN_PULSE(MIN_P), .TIMEOUT(TO_P), .RETRY_W(RW), .MAX_RETRY(MAX_R)) dut (
        .clk (clk), .rst (rst), .mgr_locked_i (lock), .reload_i (reload),
        .phy_done_i (pdone), .phy_lock_i (plock), .phy_rst_o (phy_rst),
        .mac_rst_o (mac_rst), .link_ready_o (link), .retry_cnt_o (rcnt),
        .retry_err_o (err)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reference model, bits {reload, lock, pdone, plock}
    logic [3:0] m_s1 = '0, m_s2 = '0;
    int m_st = 0, m_pc = 0, m_wd = 0, m_rc = 0;
    bit m_done = 0;

    function automatic bit f_hold(logic [3:0] s);
        return s[3] | ~s[2];
    endfunction
    function automatic bit f_elock(logic [3:0] s);
        return s[1] & s[0];
    endfunction

    always @(posedge clk) begin : mdl
        bit h, el, evt, nd;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_st = 0; m_pc = 0; m_wd = 0; m_rc = 0; m_done = 0;
        end else begin
            h   = f_hold(m_s2);
            el  = f_elock(m_s2);
            evt = (m_st == 1) && !h && !el && !m_done && (m_wd == TO_P - 1);
            if (m_s2[3]) m_rc = 0;
            else if (evt && m_rc != RMAX) m_rc++;
            nd = m_s2[3] ? 1'b0 : (m_done | (el && m_st != 0));
            if (h) begin
                m_st = 0; m_pc = 0; m_wd = 0;
            end else if (m_st == 0) begin
                m_wd = 0;
                if (m_pc == MIN_P - 1) begin m_st = 1; m_pc = 0; end
                else m_pc++;
            end else if (m_st == 1) begin
                if (el || m_done) m_st = 2;
                else if (m_wd == TO_P - 1) begin m_st = 0; m_wd = 0; m_pc = 0; end
                else m_wd++;
            end
            m_done = nd;
            m_s2 = m_s1;
            m_s1 = {reload, lock, pdone, plock};
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            chk("R2 phy_rst vs model", int'(phy_rst), int'(m_st == 0));
            chk("R5 mac_rst vs model", int'(mac_rst), int'(!m_done));
            chk("R8 link vs model", int'(link), int'(m_done & m_s2[2]));
            chk("R7 retry count vs model", int'(rcnt), m_rc);
            chk("R7 err vs model", int'(err), int'(m_rc >= MAX_R));
        end
    end

    task automatic summary();
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    task automatic wait_phy(input bit v, input int lim);
        for (int i = 0; i < lim && phy_rst != v; i++) cyc(1);
    endtask

    initial begin
        int lo, hi, rises;
        bit prev;
        void'($urandom(32'd20240611));
        cyc(3);
        chk("R10 phy_rst in reset", int'(phy_rst), 1);
        chk("R10 mac_rst in reset", int'(mac_rst), 1);
        chk("R10 link in reset", int'(link), 0);
        chk("R10 retry in reset", int'(rcnt), 0);
        chk("R10 err in reset", int'(err), 0);
        rst = 1'b0;

        // R6: watchdog window with no PHY response
        wait_phy(1'b0, 200);
        lo = 0;
        while (phy_rst == 1'b0 && lo < 1000) begin lo++; cyc(1); end
        chk("R6 watchdog window length", lo, TO_P);
        chk("R6 retry counted at reissue", int'(rcnt), 1);

        // R3: reset-done alone does not establish
        pdone = 1'b1;
        wait_phy(1'b0, 200);
        cyc(TO_P - 2);
        chk("R3 phy_done alone keeps mac_rst", int'(mac_rst), 1);

        // R7: error threshold and saturation
        for (int i = 0; i < 2000 && rcnt != RW'(MAX_R - 1); i++) cyc(1);
        chk("R7 err low below limit", int'(err), 0);
        for (int i = 0; i < 4000 && rcnt != RW'(RMAX); i++) cyc(1);
        chk("R7 count saturates", int'(rcnt), RMAX);
        chk("R7 err high at saturation", int'(err), 1);
        rises = 0; prev = phy_rst;
        for (int i = 0; i < 3 * (MIN_P + TO_P); i++) begin
            cyc(1);
            if (phy_rst && !prev) rises++;
            prev = phy_rst;
        end
        chk("R7 retries continue", int'(rises >= 2), 1);
        chk("R7 count held at max", int'(rcnt), RMAX);

        // R9 and R2: reload clears, then minimum pulse
        reload = 1'b1;
        cyc(3);
        chk("R9 reload clears retry", int'(rcnt), 0);
        chk("R9 reload clears err", int'(err), 0);
        cyc(2);
        reload = 1'b0;
        cyc(1);
        hi = 0;
        while (phy_rst == 1'b1 && hi < 1000) begin hi++; cyc(1); end
        chk("R2 minimum pulse after reload", hi, MIN_P + 1);

        plock = 1'b1;
        cyc(10);
        chk("R3 both flags establish", int'(mac_rst), 0);
        chk("R8 link up", int'(link), 1);
        chk("R5 phy released when up", int'(phy_rst), 0);

        // R1: two-flop latency of the reload request
        reload = 1'b1;
        cyc(2);
        chk("R1 no reset before sync", int'(phy_rst), 0);
        cyc(1);
        chk("R1 reset after sync", int'(phy_rst), 1);
        chk("R9 reload clears latch", int'(mac_rst), 1);
        reload = 1'b0;
        cyc(MIN_P + 10);
        chk("R5 mac released again", int'(mac_rst), 0);

        // R4: stickiness
        pdone = 1'b0;
        cyc(10);
        chk("R4 sticky after phy_done drop", int'(mac_rst), 0);
        lock = 1'b0;
        cyc(4);
        chk("R8 link follows lock", int'(link), 0);
        chk("R4 mac stays released", int'(mac_rst), 0);
        chk("R2 reset on lock loss", int'(phy_rst), 1);
        lock = 1'b1;
        cyc(MIN_P + 10);
        chk("R4 relink without phy_done", int'(link), 1);
        chk("R4 phy released after relink", int'(phy_rst), 0);

        // Random phase checked against the model
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(99) < 2)  lock  = ~lock;
            if ($urandom_range(99) < 4)  pdone = ~pdone;
            if ($urandom_range(99) < 4)  plock = ~plock;
            reload = ($urandom_range(299) == 0);
            rst    = ($urandom_range(1999) == 0);
            cyc(1);
        end
        rst = 1'b0;
        cyc(2);
        summary();
    end
endmodule